// File: doc/BRIEF.md
# Bank-striped register file with cross-bank read arbitration

This block holds 128 general registers. It spreads them over four banks by the two low bits of the register number, so register `r` sits in bank `r % 4`, row `r / 4`. Every function-unit row gets one write port and one read port. Each port arrives as a fully decoded vector with one bit per register, the form a dependency matrix already produces. Nothing inside the block has to decode a register index before it touches storage.

A write is bank-locked. Function unit `u` may only name registers whose bank equals `u % 4`. Each bank's storage is therefore fed only by its own group of units, and no unit's data crosses into another bank on the write side. If two units of a group hit the same register in one cycle, the lower unit index wins.

Reads may target any bank. Each bank drives one read data bus per cycle, four buses in total, and the units that want the same bank compete for it. The lowest unit index is granted. Every other requester sees its stall output high in that same cycle and must hold its request. A granted read delivers its data one clock later with a valid flag. The value read is the register contents from before any write at the same clock edge.

Top module: `stripe_regfile`

## Requirements
- R1: After reset every register reads as zero, and `rdValid` and `rdStall` are all low.
- R2: Register `r` is held in bank `r % 4` at row `r / 4`. A granted read of register `r` sets `rdValid[u]` on the next clock edge, and `rdDataVec` slice `u` then carries the last value written to `r`.
- R3: Bit `u*128 + r` of `wrEnVec` stores slice `u` of `wrDataVec` into register `r` at the clock edge. It is legal only when `r % 4 == u % 4`. Setting any other bit breaks the input contract.
- R4: When several units of one bank group write the same register in the same cycle, the value from the lowest unit index is stored.
- R5: Each bank serves at most one read per cycle, and the lowest-indexed requester of that bank is granted. Every other requester of the bank has `rdStall` high in the same cycle and gets no `rdValid` on the next edge.
- R6: Reads that target four different banks in one cycle are all granted together, with no stall.
- R7: A read and a write of the same register in the same cycle return the value the register held before that write.
- R8: A unit with an all-zero read-enable slice never stalls and gets no `rdValid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnVec | input | NUM_FU*NUM_REGS | Per-unit one-hot write enables, slice `u` is bits `u*128 +: 128` |
| wrDataVec | input | NUM_FU*DATA_W | Per-unit write data |
| rdEnVec | input | NUM_FU*NUM_REGS | Per-unit one-hot read enables |
| rdDataVec | output | NUM_FU*DATA_W | Per-unit read data, registered |
| rdValid | output | NUM_FU | Read data of that unit is valid this cycle |
| rdStall | output | NUM_FU | Read request lost arbitration this cycle and must be held |

## Verification
The design can go wrong in two places, the storage and the arbitration. A register stored in the wrong bank or row shows up as a wrong `rdDataVec` value one cycle after the first read of that register, which is why every register is swept with distinct values. An arbiter that grants the wrong unit, or grants two units of one bank, shows up as a wrong `rdStall` pattern in the same cycle as the request. It also shows up as a wrong `rdValid` set on the following edge. Write and read hazards on one register show up on the first read in the cycle after the clash.

// File: rtl/stripe_rf_pkg.sv
package stripe_rf_pkg;
  localparam int RF_REGS  = 128;
  localparam int RF_BANKS = 4;
  localparam int RF_FUS   = 8;
  localparam int RF_WIDTH = 16;
  localparam int RF_ROWS  = RF_REGS / RF_BANKS;
  localparam int RF_ROW_W = $clog2(RF_ROWS);

  // Per-bank read strobes from control to datapath.
  typedef struct packed {
    logic [RF_FUS-1:0]   grant;
    logic [RF_ROW_W-1:0] row;
  } bankStrobe_t;
endpackage

// File: rtl/stripe_rf_ctrl.sv
module stripe_rf_ctrl
  import stripe_rf_pkg::*;
#(
  parameter int NUM_REGS  = RF_REGS,
  parameter int NUM_BANKS = RF_BANKS,
  parameter int NUM_FU    = RF_FUS
) (
  input  logic [NUM_FU*NUM_REGS-1:0]     rdEnVec,
  output bankStrobe_t [NUM_BANKS-1:0]    strobe,
  output logic [NUM_FU-1:0]              rdStall
);
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [REG_W-1:0]     regIdx  [NUM_FU];
  logic [NUM_BANKS-1:0] reqBank [NUM_FU];
  logic [NUM_FU-1:0]    reqAny;
  logic [NUM_FU-1:0]    granted;

  // One-hot to index encode for each unit's read request.
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      regIdx[u] = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        if (rdEnVec[u*NUM_REGS + r]) regIdx[u] = regIdx[u] | REG_W'(r);
      end
      reqAny[u]  = |rdEnVec[u*NUM_REGS +: NUM_REGS];
      reqBank[u] = reqAny[u] ? (NUM_BANKS'(1) << regIdx[u][BANK_W-1:0]) : '0;
    end
  end

  // Fixed priority per bank: the lowest unit index takes the bus.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      logic taken;
      taken = 1'b0;
      strobe[b].grant = '0;
      strobe[b].row   = '0;
      for (int u = 0; u < NUM_FU; u++) begin
        if (reqBank[u][b] && !taken) begin
          strobe[b].grant[u] = 1'b1;
          strobe[b].row      = regIdx[u][REG_W-1:BANK_W];
          taken              = 1'b1;
        end
      end
    end
  end

  always_comb begin
    granted = '0;
    for (int b = 0; b < NUM_BANKS; b++) granted = granted | strobe[b].grant;
    rdStall = reqAny & ~granted;
  end
endmodule

// File: rtl/stripe_rf_data.sv
module stripe_rf_data
  import stripe_rf_pkg::*;
#(
  parameter int NUM_REGS  = RF_REGS,
  parameter int NUM_BANKS = RF_BANKS,
  parameter int NUM_FU    = RF_FUS,
  parameter int DATA_W    = RF_WIDTH
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_FU*NUM_REGS-1:0]    wrEnVec,
  input  logic [NUM_FU*DATA_W-1:0]      wrDataVec,
  input  bankStrobe_t [NUM_BANKS-1:0]   strobe,
  output logic [NUM_FU*DATA_W-1:0]      rdDataVec,
  output logic [NUM_FU-1:0]             rdValid
);
  localparam int ROWS    = NUM_REGS / NUM_BANKS;
  localparam int WRITERS = NUM_FU / NUM_BANKS;

  logic [NUM_BANKS-1:0][DATA_W-1:0] bankBus;
  logic [NUM_FU-1:0][DATA_W-1:0]    rdDataQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];

    // Only units u with u % NUM_BANKS == b reach this bank; the
    // descending loop lets the lowest-indexed writer land last.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < ROWS; k++) mem[k] <= '0;
      end else begin
        for (int k = 0; k < ROWS; k++) begin
          for (int w = WRITERS - 1; w >= 0; w--) begin
            if (wrEnVec[(w*NUM_BANKS + b)*NUM_REGS + k*NUM_BANKS + b])
              mem[k] <= wrDataVec[(w*NUM_BANKS + b)*DATA_W +: DATA_W];
          end
        end
      end
    end

    assign bankBus[b] = mem[strobe[b].row];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      rdValid <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        rdValid[u] <= 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (strobe[b].grant[u]) begin
            rdDataQ[u] <= bankBus[b];
            rdValid[u] <= 1'b1;
          end
        end
      end
    end
  end

  assign rdDataVec = rdDataQ;
endmodule

// File: rtl/stripe_regfile.sv
module stripe_regfile
  import stripe_rf_pkg::*;
#(
  parameter int NUM_REGS  = RF_REGS,
  parameter int NUM_BANKS = RF_BANKS,
  parameter int NUM_FU    = RF_FUS,
  parameter int DATA_W    = RF_WIDTH
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_FU*NUM_REGS-1:0] wrEnVec,
  input  logic [NUM_FU*DATA_W-1:0]   wrDataVec,
  input  logic [NUM_FU*NUM_REGS-1:0] rdEnVec,
  output logic [NUM_FU*DATA_W-1:0]   rdDataVec,
  output logic [NUM_FU-1:0]          rdValid,
  output logic [NUM_FU-1:0]          rdStall
);
  bankStrobe_t [NUM_BANKS-1:0] strobe;

  stripe_rf_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .NUM_FU(NUM_FU)
  ) u_ctrl (
    .rdEnVec(rdEnVec),
    .strobe (strobe),
    .rdStall(rdStall)
  );

  stripe_rf_data #(
    .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .NUM_FU(NUM_FU), .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .wrEnVec  (wrEnVec),
    .wrDataVec(wrDataVec),
    .strobe   (strobe),
    .rdDataVec(rdDataVec),
    .rdValid  (rdValid)
  );
endmodule

// File: rtl/stripe_rf_checker.sv
module stripe_rf_checker
  import stripe_rf_pkg::*;
#(
  parameter int NUM_REGS  = RF_REGS,
  parameter int NUM_BANKS = RF_BANKS,
  parameter int NUM_FU    = RF_FUS
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_FU*NUM_REGS-1:0] wrEnVec,
  input logic [NUM_FU*NUM_REGS-1:0] rdEnVec,
  input logic [NUM_FU-1:0]          rdValid,
  input logic [NUM_FU-1:0]          rdStall,
  input bankStrobe_t [NUM_BANKS-1:0] strobe
);
  function automatic logic [NUM_REGS-1:0] bankMask(int bk);
    logic [NUM_REGS-1:0] m;
    m = '0;
    for (int r = 0; r < NUM_REGS; r++) m[r] = ((r % NUM_BANKS) == bk);
    return m;
  endfunction

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    localparam logic [NUM_REGS-1:0] OWN_MASK = bankMask(u % NUM_BANKS);
    logic asking;
    assign asking = |rdEnVec[u*NUM_REGS +: NUM_REGS];

    assert_bank_locked_write_R3: assert property (@(posedge clk) disable iff (!rstN)
      (wrEnVec[u*NUM_REGS +: NUM_REGS] & ~OWN_MASK) == '0);

    assert_stall_needs_request_R8: assert property (@(posedge clk) disable iff (!rstN)
      rdStall[u] |-> asking);

    assert_grant_gives_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
      (asking && !rdStall[u]) |=> rdValid[u]);

    assert_loser_no_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
      !(asking && !rdStall[u]) |=> !rdValid[u]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
    assert_one_grant_per_bank_R5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobe[b].grant));
  end
endmodule

bind stripe_regfile stripe_rf_checker #(
  .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .NUM_FU(NUM_FU)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEnVec(wrEnVec), .rdEnVec(rdEnVec),
  .rdValid(rdValid), .rdStall(rdStall), .strobe(strobe)
);

// File: tb/stripe_regfile_tb.sv
`timescale 1ns/1ps
module stripe_regfile_tb;
  localparam int NR = 128, NB = 4, NF = 8, DW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NF*NR-1:0] wrEnVec = '0, rdEnVec = '0;
  logic [NF*DW-1:0] wrDataVec = '0;
  logic [NF*DW-1:0] rdDataVec;
  logic [NF-1:0] rdValid, rdStall;

  stripe_regfile u_dut (.clk(clk), .rstN(rstN), .wrEnVec(wrEnVec), .wrDataVec(wrDataVec),
    .rdEnVec(rdEnVec), .rdDataVec(rdDataVec), .rdValid(rdValid), .rdStall(rdStall));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int model [NR];
  int wReg [NF], wVal [NF], rReg [NF];

  task automatic check(string tag, logic ok, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    for (int u = 0; u < NF; u++) begin wReg[u] = -1; wVal[u] = 0; rReg[u] = -1; end
  endtask

  // One cycle: drive now (at a negedge), check stall, update model at the
  // edge, check read results at the next negedge.
  task automatic runCycle(string tag);
    logic [NF-1:0] expStall, expValid;
    int expData [NF];
    logic [NB-1:0] bankTaken;
    wrEnVec = '0; rdEnVec = '0; wrDataVec = '0;
    for (int u = 0; u < NF; u++) begin
      if (wReg[u] >= 0) wrEnVec[u*NR + wReg[u]] = 1'b1;
      wrDataVec[u*DW +: DW] = wVal[u][DW-1:0];
      if (rReg[u] >= 0) rdEnVec[u*NR + rReg[u]] = 1'b1;
    end
    bankTaken = '0; expStall = '0; expValid = '0;
    for (int u = 0; u < NF; u++) begin
      expData[u] = 0;
      if (rReg[u] >= 0) begin
        if (bankTaken[rReg[u] % NB]) expStall[u] = 1'b1;
        else begin bankTaken[rReg[u] % NB] = 1'b1; expValid[u] = 1'b1; end
      end
    end
    #1;
    check({tag, " stall"}, rdStall === expStall, rdStall, expStall);
    @(posedge clk);
    for (int u = 0; u < NF; u++) if (expValid[u]) expData[u] = model[rReg[u]];
    for (int u = NF - 1; u >= 0; u--) if (wReg[u] >= 0) model[wReg[u]] = wVal[u] & 16'hffff;
    @(negedge clk);
    check({tag, " valid"}, rdValid === expValid, rdValid, expValid);
    for (int u = 0; u < NF; u++)
      if (expValid[u])
        check({tag, " data"}, rdDataVec[u*DW +: DW] === expData[u][DW-1:0],
              rdDataVec[u*DW +: DW], expData[u][DW-1:0]);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = 0;
    clearReq();
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check("R1 reset valid", rdValid === '0, rdValid, 0);
    check("R1 reset stall", rdStall === '0, rdStall, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R6: all registers zero, four banks in parallel per cycle
    for (int c = 0; c < NR / NB; c++) begin
      clearReq();
      for (int u = 0; u < NB; u++) rReg[u] = c*NB + u;
      runCycle("R1 R6 zero sweep");
    end

    // R3: write every register once with a distinct value
    for (int c = 0; c < 16; c++) begin
      clearReq();
      for (int u = 0; u < NF; u++) begin
        wReg[u] = (c*2 + u/NB)*NB + (u % NB);
        wVal[u] = wReg[u]*37 + 5;
      end
      runCycle("R3 write sweep");
    end

    // R2 / R6: read every register back through units 4..7
    for (int c = 0; c < NR / NB; c++) begin
      clearReq();
      for (int u = 0; u < NB; u++) rReg[u + NB] = c*NB + ((u + c) % NB);
      runCycle("R2 R6 read sweep");
    end

    // R5: all units contend for bank 2; winners drop out one by one
    for (int k = 0; k < NF; k++) begin
      clearReq();
      for (int u = k; u < NF; u++) rReg[u] = u*NB + 2;
      runCycle("R5 contention");
    end

    // R7: read and write of register 5 in one cycle, then R3 read-back
    clearReq(); wReg[1] = 5; wVal[1] = 16'hbeef; rReg[0] = 5;
    runCycle("R7 same-cycle old value");
    clearReq(); rReg[0] = 5;
    runCycle("R3 read after write");

    // R4: units 2 and 6 both write register 10
    clearReq(); wReg[2] = 10; wVal[2] = 16'h1234; wReg[6] = 10; wVal[6] = 16'h5678;
    runCycle("R4 write tie");
    clearReq(); rReg[3] = 10;
    runCycle("R4 tie read-back");

    // R8: idle cycle
    clearReq();
    runCycle("R8 idle");

    // R2 R4 R5 R7: random legal traffic against the model
    for (int n = 0; n < 3000; n++) begin
      clearReq();
      for (int u = 0; u < NF; u++) begin
        if ($urandom % 2 == 0) begin
          wReg[u] = int'($urandom % (NR / NB))*NB + (u % NB);
          wVal[u] = int'($urandom % 65536);
        end
        if ($urandom % 3 != 0) rReg[u] = int'($urandom % NR);
      end
      runCycle("R2 R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule